// File: doc/BRIEF.md
# Interruptible Read Burst Sequencer

This block is the device-side timing engine for read bursts on a double-rate memory. It takes a command each clock, with a bank and a column. A read enters a latency pipeline. Once the programmed CAS latency has run out, the block plays out a burst of column addresses on a two-beat-per-clock beat bus and raises the enables for the data and strobe drivers. The storage array, analog timing, refresh and the write data path are all outside this block.

A burst that is still running can be replaced by a newer read to any bank, and two reads may arrive on consecutive clocks. The old burst keeps streaming until the newer read reaches its own CAS-latency point. At that clock the new read takes over with a complete burst. A burst-stop command passes through the same latency pipeline. At its latency point it turns the drivers off and ends the burst. Burst length and latency are configuration inputs and may be changed only while the block is idle.

Top module: `rd_burst_seq`

## Requirements
- R1: While `rst_n` is low, `beat_valid`, `dq_oe` and `dqs_oe` are 0.
- R2: A read (`cmd`=1) sampled at clock edge E0 makes `beat_valid` high right after edge E0+CL, where CL is 2 when `cfg_cl`=0 and 3 when `cfg_cl`=1. `beat_bank` carries the command's bank.
- R3: `cfg_bl` selects the burst length: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 gives 8 beats. `beat_valid` stays high for length/2 consecutive clocks.
- R4: Beat i of a burst with length L and start column S uses column (S & ~(L-1)) | ((S+i) & (L-1)). `beat_col0` carries the even beat of a clock and `beat_col1` the odd beat.
- R5: Both latency settings (2 and 3) apply the R2 timing.
- R6: A read that arrives while an older burst is running lets the older burst continue up to and including the clock right after the new read's edge E0+CL-1. From the next clock the new read's complete burst appears and the remaining old beats are dropped.
- R7: Reads on consecutive clocks are all accepted. Each later one takes over one clock after the one before it.
- R8: A burst stop (`cmd`=2) sampled at edge E0 turns off `beat_valid`, `dq_oe` and `dqs_oe` from just after edge E0+CL, unless a newer read takes over. A stop while idle has no visible effect.
- R9: NOP (`cmd`=0) and write (`cmd`=3) have no effect on a running burst or on the outputs.
- R10: `dq_oe` and `dqs_oe` rise one clock before a burst's first beat (preamble). They stay high across beats and takeovers and fall right after the last beat of the final burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 0 NOP, 1 read, 2 burst stop, 3 write |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_col | input | COL_W | Start column of the command |
| cfg_bl | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| cfg_cl | input | 1 | Latency select (0:2, 1:3) |
| beat_valid | output | 1 | Beat bus carries two beats this clock |
| beat_bank | output | BANK_W | Bank of the current beats |
| beat_col0 | output | COL_W | Column of the first beat of the clock |
| beat_col1 | output | COL_W | Column of the second beat of the clock |
| dq_oe | output | 1 | Data output driver enable |
| dqs_oe | output | 1 | Strobe output driver enable |

## Verification
Single reads are issued at each burst length and both latencies, with start columns inside the aligned block, so that wrap order and timing errors show up separately. Reads are placed two clocks apart and on consecutive clocks, which separates a correct latency-aligned takeover from one that switches too early or drops old beats. Burst stop is issued mid-burst and while idle, and a write is placed inside a burst to show that only stop ends one. Every clock, the outputs are compared with a scoreboard built from the requirements.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_STOP  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        TAG_NONE = 2'd0,
        TAG_READ = 2'd1,
        TAG_STOP = 2'd2
    } tag_e;
endpackage

// File: rtl/rdseq_lat_pipe.sv
module rdseq_lat_pipe
    import rdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cl_sel,
    output tag_e              arr_tag,
    output logic [BANK_W-1:0] arr_bank,
    output logic [COL_W-1:0]  arr_col
);
    localparam int IDX_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

    typedef struct packed {
        tag_e              tag;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_CL-1:0] slot;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    cmd_e  cmd_v;
    logic [IDX_W-1:0] arr_idx;

    assign cmd_v = cmd_e'(cmd);

    always_comb begin
        pipe_d = pipe_q;
        unique case (cmd_v)
            CMD_READ: pipe_d.slot[0].tag = TAG_READ;
            CMD_STOP: pipe_d.slot[0].tag = TAG_STOP;
            default:  pipe_d.slot[0].tag = TAG_NONE;
        endcase
        pipe_d.slot[0].bank = cmd_bank;
        pipe_d.slot[0].col  = cmd_col;
        for (int i = 1; i < MAX_CL; i++) begin
            pipe_d.slot[i] = pipe_q.slot[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign arr_idx  = IDX_W'(MIN_CL - 1) + IDX_W'(cl_sel);
    assign arr_tag  = pipe_q.slot[arr_idx].tag;
    assign arr_bank = pipe_q.slot[arr_idx].bank;
    assign arr_col  = pipe_q.slot[arr_idx].col;

    // R7
    read_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |=> (pipe_q.slot[0].tag == TAG_READ));

    generate
        for (genvar g = 1; g < MAX_CL; g++) begin : g_shift
            // R2
            stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (pipe_q.slot[g] == $past(pipe_q.slot[g-1])));
        end
    endgenerate
endmodule

// File: rtl/rdseq_burst.sv
module rdseq_burst
    import rdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int MAX_BL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tag_e              arr_tag,
    input  logic [BANK_W-1:0] arr_bank,
    input  logic [COL_W-1:0]  arr_col,
    input  logic [1:0]        cfg_bl,
    output logic              active,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col0,
    output logic [COL_W-1:0]  col1
);
    localparam int KW = (MAX_BL > 2) ? $clog2(MAX_BL / 2) : 1;

    typedef struct packed {
        logic              active;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  start;
        logic [KW-1:0]     k;
    } beng_t;

    beng_t s_d, s_q;
    logic [1:0]       code_c;
    logic [KW-1:0]    last_k;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] off;

    assign code_c = (cfg_bl > 2'd2) ? 2'd2 : cfg_bl;
    assign last_k = KW'((1 << code_c) - 1);
    assign mask   = COL_W'((2 << code_c) - 1);

    always_comb begin
        s_d = s_q;
        if (arr_tag == TAG_READ) begin
            s_d.active = 1'b1;
            s_d.bank   = arr_bank;
            s_d.start  = arr_col;
            s_d.k      = '0;
        end else if (arr_tag == TAG_STOP) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            if (s_q.k == last_k) s_d.active = 1'b0;
            else                 s_d.k      = s_q.k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign off    = COL_W'({s_q.k, 1'b0});
    assign active = s_q.active;
    assign bank   = s_q.bank;
    assign col0   = (s_q.start & ~mask) | ((s_q.start + off) & mask);
    assign col1   = (s_q.start & ~mask) | ((s_q.start + off + COL_W'(1)) & mask);

    // R8
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_tag == TAG_STOP) |=> !s_q.active);

    // R6
    takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_tag == TAG_READ) |=> (s_q.active && s_q.k == '0 && s_q.start == $past(arr_col)));

    // R3
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.k <= last_k));
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
    import rdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 3,
    parameter int MAX_BL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_cl,
    output logic              beat_valid,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col0,
    output logic [COL_W-1:0]  beat_col1,
    output logic              dq_oe,
    output logic              dqs_oe
);
    tag_e              arr_tag;
    logic [BANK_W-1:0] arr_bank;
    logic [COL_W-1:0]  arr_col;
    logic              drv_en;

    rdseq_lat_pipe #(
        .BANK_W(BANK_W), .COL_W(COL_W), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cl_sel(cfg_cl), .arr_tag(arr_tag),
        .arr_bank(arr_bank), .arr_col(arr_col)
    );

    rdseq_burst #(
        .BANK_W(BANK_W), .COL_W(COL_W), .MAX_BL(MAX_BL)
    ) u_burst (
        .clk(clk), .rst_n(rst_n), .arr_tag(arr_tag), .arr_bank(arr_bank),
        .arr_col(arr_col), .cfg_bl(cfg_bl), .active(beat_valid),
        .bank(beat_bank), .col0(beat_col0), .col1(beat_col1)
    );

    // Preamble: a read at its latency point opens the drivers one clock early.
    assign drv_en = beat_valid | (arr_tag == TAG_READ);
    assign dq_oe  = drv_en;
    assign dqs_oe = drv_en;

    // R10
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> $past(dq_oe));
endmodule

// File: tb/rd_burst_seq_bench.sv
module rd_burst_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 2;
    localparam int COL_W  = 10;
    localparam int DEPTH  = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd = 2'd0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [1:0]        cfg_bl = 2'd1;
    logic              cfg_cl = 1'b1;
    logic              beat_valid;
    logic [BANK_W-1:0] beat_bank;
    logic [COL_W-1:0]  beat_col0, beat_col1;
    logic              dq_oe, dqs_oe;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit monitor_on = 1'b0;

    // scoreboard: expected output per clock, filled by the driver
    bit                e_oe   [DEPTH];
    bit                e_vld  [DEPTH];
    logic [BANK_W-1:0] e_bank [DEPTH];
    logic [COL_W-1:0]  e_c0   [DEPTH];
    logic [COL_W-1:0]  e_c1   [DEPTH];
    string             e_req  [DEPTH];

    rd_burst_seq u_rd_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
        .beat_valid(beat_valid), .beat_bank(beat_bank),
        .beat_col0(beat_col0), .beat_col1(beat_col1),
        .dq_oe(dq_oe), .dqs_oe(dqs_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [COL_W-1:0] wrap_col(logic [COL_W-1:0] s, int len, int i);
        logic [COL_W-1:0] m = COL_W'(len - 1);
        return (s & ~m) | ((s + COL_W'(i)) & m);
    endfunction

    function automatic int blen();
        return (cfg_bl == 2'd0) ? 2 : (cfg_bl == 2'd1) ? 4 : 8;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at cyc %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic clear_from(int from, string req);
        for (int i = from; i < DEPTH; i++) begin
            e_oe[i] = 0; e_vld[i] = 0; e_req[i] = req;
        end
    endtask

    task automatic issue_read(logic [BANK_W-1:0] b, logic [COL_W-1:0] c, string req);
        int lat, len, s;
        @(negedge clk);
        cmd = 2'd1; cmd_bank = b; cmd_col = c;
        lat = cfg_cl ? 3 : 2;
        len = blen();
        s = cyc + lat;
        clear_from(s + 1, "R10");
        e_oe[s] = 1;
        for (int j = 0; j < len / 2; j++) begin
            e_oe[s+1+j] = 1; e_vld[s+1+j] = 1; e_bank[s+1+j] = b;
            e_c0[s+1+j] = wrap_col(c, len, 2*j);
            e_c1[s+1+j] = wrap_col(c, len, 2*j + 1);
            e_req[s+1+j] = req;
        end
    endtask

    task automatic issue_stop();
        int lat;
        @(negedge clk);
        cmd = 2'd2; cmd_bank = '0; cmd_col = '0;
        lat = cfg_cl ? 3 : 2;
        clear_from(cyc + lat + 1, "R8");
    endtask

    task automatic issue_write(logic [COL_W-1:0] c);
        @(negedge clk);
        cmd = 2'd3; cmd_bank = 2'd2; cmd_col = c;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd = 2'd0;
        end
    endtask

    // monitor: compare every clock against the scoreboard
    always @(negedge clk) begin
        if (monitor_on && cyc < DEPTH) begin
            check(e_req[cyc], "beat_valid", int'(beat_valid), int'(e_vld[cyc]));
            check(e_req[cyc], "dq_oe", int'(dq_oe), int'(e_oe[cyc]));
            check(e_req[cyc], "dqs_oe", int'(dqs_oe), int'(e_oe[cyc]));
            if (e_vld[cyc]) begin
                check(e_req[cyc], "beat_bank", int'(beat_bank), int'(e_bank[cyc]));
                check(e_req[cyc], "beat_col0", int'(beat_col0), int'(e_c0[cyc]));
                check(e_req[cyc], "beat_col1", int'(beat_col1), int'(e_c1[cyc]));
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            e_oe[i] = 0; e_vld[i] = 0; e_bank[i] = '0;
            e_c0[i] = '0; e_c1[i] = '0; e_req[i] = "R10";
        end
        rst_n = 1'b0;
        cmd = 2'd1; cmd_col = 10'd7;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset even with a read driven
        check("R1", "beat_valid in reset", int'(beat_valid), 0);
        check("R1", "dq_oe in reset", int'(dq_oe), 0);
        check("R1", "dqs_oe in reset", int'(dqs_oe), 0);
        cmd = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        monitor_on = 1'b1;
        idle(2);

        cfg_cl = 1'b1; cfg_bl = 2'd1;
        issue_read(2'd1, 10'd5, "R2");    idle(8);
        cfg_bl = 2'd0;
        issue_read(2'd2, 10'd10, "R3");   idle(6);
        cfg_bl = 2'd2;
        issue_read(2'd0, 10'd13, "R4");   idle(10);
        cfg_cl = 1'b0; cfg_bl = 2'd1;
        issue_read(2'd3, 10'd34, "R5");   idle(8);
        cfg_bl = 2'd3;
        issue_read(2'd1, 10'd21, "R5");   idle(10);

        cfg_cl = 1'b1; cfg_bl = 2'd2;
        issue_read(2'd0, 10'd40, "R6");   idle(2);
        issue_read(2'd1, 10'd100, "R6");  idle(12);
        cfg_bl = 2'd1;
        issue_read(2'd0, 10'd8, "R7");
        issue_read(2'd2, 10'd17, "R7");
        issue_read(2'd3, 10'd30, "R7");   idle(10);

        cfg_bl = 2'd2;
        issue_read(2'd2, 10'd50, "R8");   idle(1);
        issue_stop();                     idle(10);
        issue_stop();                     idle(6);
        cfg_bl = 2'd1;
        issue_read(2'd1, 10'd3, "R9");
        issue_write(10'd99);              idle(1);
        issue_write(10'd77);              idle(8);

        cfg_cl = 1'b0; cfg_bl = 2'd2;
        issue_read(2'd3, 10'd60, "R6");   idle(1);
        issue_read(2'd0, 10'd70, "R6");   idle(1);
        issue_stop();                     idle(10);
        cfg_bl = 2'd0;
        issue_read(2'd1, 10'd91, "R10");  idle(1);
        issue_read(2'd2, 10'd92, "R10");  idle(8);

        monitor_on = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule